// File: doc/BRIEF.md
# Single-Wire ROM Search Enumerator

This block finds the 64-bit identifiers of every device sharing a single-wire bus by walking the binary search tree that the bus's search command exposes. For every pass it first asks an external command sequencer to put out a bus reset and the search command. It then performs 64 bit triplets through an external bit-slot engine: two read slots (the identifier bit, then its complement), followed by one write slot carrying the chosen branch. The devices whose bit disagrees with the written branch drop out. At the end of a pass exactly one identifier is left.

The block remembers the highest position in the pass where a conflict was resolved toward zero. The next pass replays the previous identifier below that position, takes one at it, and takes zero above it. Every branch is visited in turn. Each identifier is validated with an 8-bit CRC that is computed bit by bit while the triplets run. A good identifier is offered on a valid/ready output together with its family byte. A bad one is dropped with a one-cycle status pulse. A missing answer restarts the pass, and a bounded number of restarts and passes protects against a broken bus.

Top module: `rom_search_enum`

## Requirements
- R1: Each bit position reads the pair {complement, bit} as code = bit | complement<<1. Code 1 writes a one and code 2 writes a zero, so a lone device is returned unchanged, including the all-zero identifier.
- R2: On a conflict (code 0), the chosen bit depends on where the position lies relative to the last zero-taken position of the previous pass. Below it, the bit is copied from the previous identifier; at it, the bit is one; above it, the bit is zero. In the first pass every conflict takes zero. As a result, identifiers come out in ascending order of their bit-reversed value (bit 0 most significant), each device once.
- R3: Code 3 (no answer) abandons the pass and requests a new reset/search without touching the search state. The counter of consecutive restarts clears after any complete pass. When code 3 arrives while MAX_RETRY restarts have already been made, the block pulses err_io and returns to idle, so with the default this happens after 6 sequencer requests.
- R4: After MAX_PASSES completed passes (default 11), if another pass is still needed the block pulses err_limit and returns to idle instead of requesting it.
- R5: An identifier is valid when the reflected CRC-8 over its 64 bits is zero. Bits are fed in from bit 0 upward, the register starts at 0, and the polynomial is x^8+x^5+x^4+1 (shift-right constant 0x8C). An invalid identifier is never offered on the output; instead crc_bad pulses once and the search continues.
- R6: id_family equals bits 7:0 of id_data while id_valid is high.
- R7: Once id_valid is high, it stays high and id_data stays unchanged until a cycle with id_ready high.
- R8: After a pass that took no conflict toward zero, the block finishes the pass's output and then pulses done. It returns to idle (busy low). Exactly one of done, err_io and err_limit ends each run started by start.
- R9: One sequencer request precedes every pass and every restart. The bit interface carries one slot at a time, held until acknowledged, in the order read, read, write for each position.
- R10: After reset, busy, seq_req, bit_req, id_valid, crc_bad, done, err_io and err_limit are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an enumeration run (ignored while busy) |
| busy | output | 1 | A run is in progress |
| seq_req | output | 1 | Request reset plus search command from the sequencer |
| seq_ack | input | 1 | Sequencer finished the request |
| bit_req | output | 1 | Bit slot requested |
| bit_wr | output | 1 | 1 = write slot, 0 = read slot |
| bit_wval | output | 1 | Value for a write slot |
| bit_ack | input | 1 | Bit slot finished |
| bit_rval | input | 1 | Value sampled by a read slot, valid with bit_ack |
| id_valid | output | 1 | A validated identifier is offered |
| id_ready | input | 1 | Consumer accepts the identifier |
| id_data | output | 64 | Identifier, bit 0 first on the bus |
| id_family | output | 8 | Family byte of the identifier |
| crc_bad | output | 1 | Pulse: identifier failed its CRC and was dropped |
| done | output | 1 | Pulse: run ended after the last branch |
| err_io | output | 1 | Pulse: too many consecutive silent passes |
| err_limit | output | 1 | Pulse: pass budget used up |

## Verification
The hardest states to reach from the ports are deep conflict replays, where a pass must copy many bits from the previous identifier before branching. The run that reaches the pass limit exactly is another. The stimulus reaches both through a behavioural wired-AND bus model holding a configurable device population. Populations include identifiers that share a long low-order prefix, random sets, a set containing corrupted checksums, and populations of exactly 11 and 12 devices. The model can also force a no-answer response at a chosen bit position for five or six passes in a row. This places a restart at the edge of its budget. Expected output order comes from sorting the population by bit-reversed value in the bench.

// File: rtl/rse_pkg.sv
package rse_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEQ,
    ST_RDA,
    ST_RDB,
    ST_WR,
    ST_CHK,
    ST_EMIT,
    ST_NEXT
  } rse_state_e;

  // pair code = first | second << 1
  localparam logic [1:0] PAIR_SPLIT = 2'd0;
  localparam logic [1:0] PAIR_ONES  = 2'd1;
  localparam logic [1:0] PAIR_ZEROS = 2'd2;
  localparam logic [1:0] PAIR_MUTE  = 2'd3;

  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;
endpackage

// File: rtl/rse_rst_sync.sv
module rse_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rse_crc8.sv
module rse_crc8 #(
  parameter int         W    = 8,
  parameter logic [W-1:0] POLY = rse_pkg::CRC_POLY_REFL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  always_comb begin
    fb    = crc_q[0] ^ din;
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = (crc_q >> 1) ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/rse_dir_pick.sv
module rse_dir_pick #(
  parameter int ID_W  = 64,
  parameter int IDX_W = $clog2(ID_W)
) (
  input  logic [1:0]       pair,
  input  logic [IDX_W-1:0] idx,
  input  logic             prior_vld,
  input  logic [IDX_W-1:0] prior_idx,
  input  logic [ID_W-1:0]  prev_id,
  output logic             dir,
  output logic             zero_split,
  output logic             mute
);
  timeunit 1ns;
  timeprecision 1ps;
  import rse_pkg::*;

  logic split_dir;

  always_comb begin
    if (prior_vld && (idx < prior_idx))       split_dir = prev_id[idx];
    else if (prior_vld && (idx == prior_idx)) split_dir = 1'b1;
    else                                      split_dir = 1'b0;
  end

  always_comb begin
    dir        = 1'b0;
    zero_split = 1'b0;
    mute       = 1'b0;
    case (pair)
      PAIR_ONES:  dir = 1'b1;
      PAIR_ZEROS: dir = 1'b0;
      PAIR_SPLIT: begin
        dir        = split_dir;
        zero_split = ~split_dir;
      end
      default:    mute = 1'b1;
    endcase
  end
endmodule

// File: rtl/rse_limit_cnt.sv
module rse_limit_cnt #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_lim
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign at_lim = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                  cnt_d = '0;
    else if (inc && !at_lim)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rom_search_enum.sv
module rom_search_enum #(
  parameter int ID_W       = 64,
  parameter int MAX_PASSES = 11,
  parameter int MAX_RETRY  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            seq_req,
  input  logic            seq_ack,
  output logic            bit_req,
  output logic            bit_wr,
  output logic            bit_wval,
  input  logic            bit_ack,
  input  logic            bit_rval,
  output logic            id_valid,
  input  logic            id_ready,
  output logic [ID_W-1:0] id_data,
  output logic [7:0]      id_family,
  output logic            crc_bad,
  output logic            done,
  output logic            err_io,
  output logic            err_limit
);
  timeunit 1ns;
  timeprecision 1ps;
  import rse_pkg::*;

  localparam int               IDX_W    = $clog2(ID_W);
  localparam int               FAM_W    = 8;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

  logic rst_ni;

  rse_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  rse_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             first_q, first_d;
  logic             dir_q, dir_d;
  logic             zs_q, zs_d;
  logic             prior_vld_q, prior_vld_d;
  logic [IDX_W-1:0] prior_idx_q, prior_idx_d;
  logic             new_vld_q, new_vld_d;
  logic [IDX_W-1:0] new_idx_q, new_idx_d;
  logic [ID_W-1:0]  cur_id_q, cur_id_d;
  logic [ID_W-1:0]  prev_id_q, prev_id_d;
  logic             done_q, done_d;
  logic             err_io_q, err_io_d;
  logic             err_lim_q, err_lim_d;
  logic             crc_bad_q, crc_bad_d;

  logic             pick_dir, pick_zero, pick_mute;
  logic [7:0]       crc_val;
  logic             crc_clr, crc_en;
  logic             pass_full, retry_full;
  logic             run_clr, retry_inc;

  rse_dir_pick #(.ID_W(ID_W), .IDX_W(IDX_W)) u_pick (
    .pair       ({bit_rval, first_q}),
    .idx        (idx_q),
    .prior_vld  (prior_vld_q),
    .prior_idx  (prior_idx_q),
    .prev_id    (prev_id_q),
    .dir        (pick_dir),
    .zero_split (pick_zero),
    .mute       (pick_mute)
  );

  assign crc_clr = (state_q == ST_SEQ) && seq_ack;
  assign crc_en  = (state_q == ST_WR) && bit_ack;

  rse_crc8 #(.W(8), .POLY(CRC_POLY_REFL)) u_crc (
    .clk (clk),
    .rst_n (rst_ni),
    .clr (crc_clr),
    .en  (crc_en),
    .din (dir_q),
    .crc (crc_val)
  );

  assign run_clr = (state_q == ST_IDLE) && start;

  rse_limit_cnt #(.LIMIT(MAX_PASSES)) u_pass (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clr    (run_clr),
    .inc    (state_q == ST_CHK),
    .at_lim (pass_full)
  );

  rse_limit_cnt #(.LIMIT(MAX_RETRY)) u_retry (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clr    (run_clr || (state_q == ST_CHK)),
    .inc    (retry_inc),
    .at_lim (retry_full)
  );

  // next-state process
  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    first_d     = first_q;
    dir_d       = dir_q;
    zs_d        = zs_q;
    prior_vld_d = prior_vld_q;
    prior_idx_d = prior_idx_q;
    new_vld_d   = new_vld_q;
    new_idx_d   = new_idx_q;
    cur_id_d    = cur_id_q;
    prev_id_d   = prev_id_q;
    done_d      = 1'b0;
    err_io_d    = 1'b0;
    err_lim_d   = 1'b0;
    crc_bad_d   = 1'b0;
    retry_inc   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          prior_vld_d = 1'b0;
          state_d     = ST_SEQ;
        end
      end
      ST_SEQ: begin
        if (seq_ack) begin
          idx_d     = '0;
          new_vld_d = 1'b0;
          state_d   = ST_RDA;
        end
      end
      ST_RDA: begin
        if (bit_ack) begin
          first_d = bit_rval;
          state_d = ST_RDB;
        end
      end
      ST_RDB: begin
        if (bit_ack) begin
          if (pick_mute) begin
            if (retry_full) begin
              err_io_d = 1'b1;
              state_d  = ST_IDLE;
            end else begin
              retry_inc = 1'b1;
              state_d   = ST_SEQ;
            end
          end else begin
            dir_d   = pick_dir;
            zs_d    = pick_zero;
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (bit_ack) begin
          cur_id_d = {dir_q, cur_id_q[ID_W-1:1]};
          if (zs_q) begin
            new_vld_d = 1'b1;
            new_idx_d = idx_q;
          end
          if (idx_q == IDX_LAST) begin
            state_d = ST_CHK;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_RDA;
          end
        end
      end
      ST_CHK: begin
        prev_id_d   = cur_id_q;
        prior_vld_d = new_vld_q;
        prior_idx_d = new_idx_q;
        if (crc_val == '0) begin
          state_d = ST_EMIT;
        end else begin
          crc_bad_d = 1'b1;
          state_d   = ST_NEXT;
        end
      end
      ST_EMIT: begin
        if (id_ready) state_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (!prior_vld_q) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (pass_full) begin
          err_lim_d = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          state_d = ST_SEQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      first_q     <= 1'b0;
      dir_q       <= 1'b0;
      zs_q        <= 1'b0;
      prior_vld_q <= 1'b0;
      prior_idx_q <= '0;
      new_vld_q   <= 1'b0;
      new_idx_q   <= '0;
      cur_id_q    <= '0;
      prev_id_q   <= '0;
      done_q      <= 1'b0;
      err_io_q    <= 1'b0;
      err_lim_q   <= 1'b0;
      crc_bad_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      first_q     <= first_d;
      dir_q       <= dir_d;
      zs_q        <= zs_d;
      prior_vld_q <= prior_vld_d;
      prior_idx_q <= prior_idx_d;
      new_vld_q   <= new_vld_d;
      new_idx_q   <= new_idx_d;
      cur_id_q    <= cur_id_d;
      prev_id_q   <= prev_id_d;
      done_q      <= done_d;
      err_io_q    <= err_io_d;
      err_lim_q   <= err_lim_d;
      crc_bad_q   <= crc_bad_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign seq_req   = (state_q == ST_SEQ);
  assign bit_req   = (state_q == ST_RDA) || (state_q == ST_RDB) || (state_q == ST_WR);
  assign bit_wr    = (state_q == ST_WR);
  assign bit_wval  = dir_q;
  assign id_valid  = (state_q == ST_EMIT);
  assign id_data   = prev_id_q;
  assign id_family = prev_id_q[FAM_W-1:0];
  assign crc_bad   = crc_bad_q;
  assign done      = done_q;
  assign err_io    = err_io_q;
  assign err_limit = err_lim_q;
endmodule

// File: rtl/rse_chk.sv
module rse_chk #(
  parameter int ID_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            seq_req,
  input logic            seq_ack,
  input logic            bit_req,
  input logic            bit_wr,
  input logic            bit_wval,
  input logic            bit_ack,
  input logic            id_valid,
  input logic            id_ready,
  input logic [ID_W-1:0] id_data,
  input logic            crc_bad,
  input logic            done,
  input logic            err_io,
  input logic            err_limit
);
  timeunit 1ns;
  timeprecision 1ps;

  function automatic logic [7:0] crc_of(input logic [ID_W-1:0] v);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < ID_W; i++)
      c = (c >> 1) ^ ((c[0] ^ v[i]) ? 8'h8C : 8'h00);
    return c;
  endfunction

  // R7
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && !id_ready |=> id_valid && $stable(id_data));

  // R5
  id_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (crc_of(id_data) == 8'h00));

  // R9
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_req && bit_req));

  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && !bit_ack |=> bit_req && $stable(bit_wr) && $stable(bit_wval));

  // R9
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && !seq_ack |=> seq_req);

  // R8
  end_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_io, err_limit, crc_bad}));

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_io || err_limit) |-> !busy);
endmodule

bind rom_search_enum rse_chk #(.ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .seq_req   (seq_req),
  .seq_ack   (seq_ack),
  .bit_req   (bit_req),
  .bit_wr    (bit_wr),
  .bit_wval  (bit_wval),
  .bit_ack   (bit_ack),
  .id_valid  (id_valid),
  .id_ready  (id_ready),
  .id_data   (id_data),
  .crc_bad   (crc_bad),
  .done      (done),
  .err_io    (err_io),
  .err_limit (err_limit)
);

// File: tb/sim_rom_search_enum.sv
module sim_rom_search_enum;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ID_W   = 64;
  localparam int MAXP   = 11;
  localparam int MAXR   = 5;
  localparam int MAXDEV = 16;
  localparam int END_DONE = 0;
  localparam int END_IO   = 1;
  localparam int END_LIM  = 2;

  logic            clk, rst_n, start;
  logic            busy, seq_req, seq_ack;
  logic            bit_req, bit_wr, bit_wval, bit_ack, bit_rval;
  logic            id_valid, id_ready;
  logic [ID_W-1:0] id_data;
  logic [7:0]      id_family;
  logic            crc_bad, done, err_io, err_limit;

  rom_search_enum #(.ID_W(ID_W), .MAX_PASSES(MAXP), .MAX_RETRY(MAXR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .seq_req(seq_req), .seq_ack(seq_ack),
    .bit_req(bit_req), .bit_wr(bit_wr), .bit_wval(bit_wval),
    .bit_ack(bit_ack), .bit_rval(bit_rval),
    .id_valid(id_valid), .id_ready(id_ready), .id_data(id_data),
    .id_family(id_family), .crc_bad(crc_bad), .done(done),
    .err_io(err_io), .err_limit(err_limit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // bus model state
  logic [ID_W-1:0] dev_id [MAXDEV];
  int              ndev = 0;
  logic [MAXDEV-1:0] active;
  int              pos, rphase;
  logic            glitch_now;
  int              glitch_pos = 0;
  int              glitch_left = 0;
  int              seq_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [ID_W-1:0] act, input logic [ID_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_bits(input logic [ID_W-1:0] v, input int n);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (c[0] ^ v[i]) c = (c >> 1) ^ 8'h8C;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [ID_W-1:0] make_id(input logic [55:0] body, input bit good);
    logic [7:0] c;
    c = crc_bits({8'h00, body}, 56);
    return {(good ? c : (c ^ 8'h5A)), body};
  endfunction

  function automatic logic [ID_W-1:0] rev(input logic [ID_W-1:0] v);
    logic [ID_W-1:0] r;
    for (int i = 0; i < ID_W; i++) r[i] = v[ID_W-1-i];
    return r;
  endfunction

  function automatic logic [55:0] rnd56();
    return {$urandom_range(0, 255), $urandom(), $urandom()} ;
  endfunction

  // responder: sequencer and bit-slot engine over a wired-AND bus
  initial begin
    seq_ack  = 1'b0;
    bit_ack  = 1'b0;
    bit_rval = 1'b0;
    active   = '0;
    pos      = 0;
    rphase   = 0;
    glitch_now = 1'b0;
    forever begin
      @(negedge clk);
      if (seq_ack || bit_ack) begin
        seq_ack = 1'b0;
        bit_ack = 1'b0;
      end else if (seq_req) begin
        if ($urandom_range(0, 2) != 0) begin
          seq_ack = 1'b1;
          seq_cnt++;
          active = '0;
          for (int k = 0; k < ndev; k++) active[k] = 1'b1;
          pos    = 0;
          rphase = 0;
        end
      end else if (bit_req) begin
        if ($urandom_range(0, 2) != 0) begin
          logic r;
          r = 1'b1;
          if (!bit_wr) begin
            if (rphase == 0) begin
              glitch_now = (glitch_left > 0) && (pos == glitch_pos);
              for (int k = 0; k < ndev; k++)
                if (active[k] && !dev_id[k][pos]) r = 1'b0;
              if (glitch_now) r = 1'b1;
              rphase = 1;
            end else begin
              for (int k = 0; k < ndev; k++)
                if (active[k] && dev_id[k][pos]) r = 1'b0;
              if (glitch_now) begin
                r = 1'b1;
                glitch_left--;
              end
              rphase = 0;
            end
            bit_rval = r;
          end else begin
            for (int k = 0; k < ndev; k++)
              if (active[k] && (dev_id[k][pos] != bit_wval)) active[k] = 1'b0;
            pos++;
            rphase = 0;
          end
          bit_ack = 1'b1;
        end
      end
    end
  end

  task automatic run_case(input string tag, input int exp_end, input int extra_seq);
    int ord [MAXDEV];
    logic [ID_W-1:0] exp_list [MAXDEV];
    logic [ID_W-1:0] got_list [MAXDEV];
    int visited, nexp, nexp_bad, ngot, ncrc, end_kind;
    logic [ID_W-1:0] last_data;
    bit  stalled;
    for (int k = 0; k < ndev; k++) ord[k] = k;
    for (int a = 0; a < ndev; a++)
      for (int b = a + 1; b < ndev; b++)
        if (rev(dev_id[ord[b]]) < rev(dev_id[ord[a]])) begin
          int t;
          t = ord[a]; ord[a] = ord[b]; ord[b] = t;
        end
    visited = (exp_end == END_IO) ? 0 : ((ndev > MAXP) ? MAXP : ndev);
    nexp = 0;
    nexp_bad = 0;
    for (int k = 0; k < visited; k++) begin
      if (crc_bits(dev_id[ord[k]], ID_W) == 8'h00) begin
        exp_list[nexp] = dev_id[ord[k]];
        nexp++;
      end else begin
        nexp_bad++;
      end
    end

    seq_cnt  = 0;
    ngot     = 0;
    ncrc     = 0;
    end_kind = -1;
    stalled  = 1'b0;
    last_data = '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: busy right after start
    chk(busy == 1'b1, "R8", {tag, " busy after start"}, ID_W'(busy), 1);
    for (int cyc = 0; cyc < 60000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (crc_bad) ncrc++;
      if (done)      end_kind = END_DONE;
      if (err_io)    end_kind = END_IO;
      if (err_limit) end_kind = END_LIM;
      if (id_valid) begin
        // R6
        chk(id_family == id_data[7:0], "R6", {tag, " family"}, ID_W'(id_family), ID_W'(id_data[7:0]));
        // R7
        if (stalled)
          chk(id_data == last_data, "R7", {tag, " stall hold"}, id_data, last_data);
        id_ready = ($urandom_range(0, 3) != 0);
        if (id_ready) begin
          if (ngot < MAXDEV) got_list[ngot] = id_data;
          ngot++;
          stalled = 1'b0;
        end else begin
          stalled   = 1'b1;
          last_data = id_data;
        end
      end else begin
        id_ready = 1'b0;
      end
      if (end_kind >= 0) break;
    end
    id_ready = 1'b0;

    // R8/R3/R4
    chk(end_kind == exp_end, (exp_end == END_IO) ? "R3" : ((exp_end == END_LIM) ? "R4" : "R8"),
        {tag, " ending"}, ID_W'(end_kind), ID_W'(exp_end));
    // R2
    chk(ngot == nexp, "R2", {tag, " id count"}, ID_W'(ngot), ID_W'(nexp));
    for (int k = 0; k < nexp && k < ngot; k++)
      chk(got_list[k] == exp_list[k], "R2", {tag, $sformatf(" id #%0d", k)}, got_list[k], exp_list[k]);
    // R5
    chk(ncrc == nexp_bad, "R5", {tag, " crc drops"}, ID_W'(ncrc), ID_W'(nexp_bad));
    // R9
    chk(seq_cnt == visited + extra_seq, "R9", {tag, " sequencer requests"},
        ID_W'(seq_cnt), ID_W'(visited + extra_seq));
    @(negedge clk);
    chk(busy == 1'b0, "R8", {tag, " idle after end"}, ID_W'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    start    = 1'b0;
    id_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({busy, seq_req, bit_req, id_valid, crc_bad, done, err_io, err_limit} == 8'h00,
        "R10", "outputs in reset", ID_W'({busy, seq_req, bit_req, id_valid, crc_bad, done, err_io, err_limit}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, seq_req, bit_req, id_valid} == 4'h0, "R10", "outputs after reset",
        ID_W'({busy, seq_req, bit_req, id_valid}), 0);

    // R1: lone device, all-zero identifier
    ndev = 1;
    dev_id[0] = '0;
    run_case("R1 zero id", END_DONE, 0);

    // R1: lone device, mostly ones
    dev_id[0] = make_id(56'hFF_FFFF_FFFF_FFFF, 1'b1);
    run_case("R1 ones id", END_DONE, 0);

    // R2: long shared low-order prefix
    begin
      logic [55:0] b;
      b = rnd56();
      ndev = 3;
      dev_id[0] = make_id(b, 1'b1);
      dev_id[1] = make_id(b ^ (56'h1 << 50), 1'b1);
      dev_id[2] = make_id(b ^ (56'h1 << 41), 1'b1);
      run_case("R2 shared prefix", END_DONE, 0);
    end

    // R2: random populations
    for (int r = 0; r < 4; r++) begin
      ndev = $urandom_range(2, 8);
      for (int k = 0; k < ndev; k++) dev_id[k] = make_id(rnd56(), 1'b1);
      run_case($sformatf("R2 random set %0d", r), END_DONE, 0);
    end

    // R5: corrupted identifiers mixed in
    ndev = 5;
    for (int k = 0; k < ndev; k++) dev_id[k] = make_id(rnd56(), (k % 2) == 0);
    run_case("R5 crc mix", END_DONE, 0);

    // R3: five silent passes in a row are survived
    ndev = 4;
    for (int k = 0; k < ndev; k++) dev_id[k] = make_id(rnd56(), 1'b1);
    glitch_pos  = 17;
    glitch_left = MAXR;
    run_case("R3 five restarts", END_DONE, MAXR);

    // R3: six silent passes end with err_io
    glitch_pos  = 3;
    glitch_left = MAXR + 1;
    run_case("R3 six restarts", END_IO, MAXR + 1);
    glitch_left = 0;

    // R3: empty bus
    ndev = 0;
    run_case("R3 empty bus", END_IO, MAXR + 1);

    // R4: exactly the pass budget
    ndev = MAXP;
    for (int k = 0; k < ndev; k++) dev_id[k] = make_id(rnd56(), 1'b1);
    run_case("R4 at budget", END_DONE, 0);

    // R4: one device beyond the budget
    ndev = MAXP + 1;
    for (int k = 0; k < ndev; k++) dev_id[k] = make_id(rnd56(), 1'b1);
    run_case("R4 over budget", END_LIM, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule